// File: doc/BRIEF.md
# Single-Cycle 32-bit Subset Processor Core

This block is a small 32-bit processor that completes one instruction per clock. Its instruction store and data store are word arrays kept inside the block. It has a 32-entry register file, an adder/comparator ALU, and a next-PC unit. The supported operations are add, sub and slt on registers, addi, word load and store, beq and bne branches, and the j, jal and jr control transfers.

A host fills the instruction store through a load port while reset is held. It then releases reset and waits for the core to reach its halt instruction. The host reads results back through a debug register-read port, and the program counter is visible as an output. Instructions the core does not recognise, and word accesses that are not aligned, do nothing except set a sticky flag.

Top module: `scp_core`

## Requirements
- R1: While rst_n is low at a rising clock edge, the core is reset: pc becomes 0, every register becomes 0, and halted and illegal become 0.
- R2: Register-form instructions have opcode 000000 with fields opcode[31:26], rs[25:21], rt[20:16], rd[15:11], shamt[10:6] and funct[5:0]. With shamt zero, funct 100000 writes rs+rt to rd, 100010 writes rs−rt to rd, and 101010 writes 1 to rd when rs is less than rt as signed values and 0 otherwise.
- R3: addi (opcode 001000) writes rs plus the sign-extended 16-bit immediate into rt. The immediate covers −32768 to 32767.
- R4: lw (opcode 100011) loads rt from data word address rs+sign-extended offset. sw (opcode 101011) stores rt to that address. A stored word stays readable by later loads.
- R5: Register 0 always reads as 0, and a write to it leaves it 0.
- R6: beq (opcode 000100) and bne (opcode 000101) compare rs with rt. When the branch is taken, the next PC is PC+4 plus the immediate shifted left by two, and a negative immediate branches backward. Every other non-transfer instruction advances the PC by 4.
- R7: j (opcode 000010) and jal (opcode 000011) jump to the upper 4 bits of PC+4, then the 26-bit field, then 00. jal also writes PC+4 into register 31. jr (register form, funct 001000) loads the PC from rs.
- R8: The word with opcode 111111 halts the core: halted rises, and pc stays at the address of the halt word until reset.
- R9: An unknown opcode, an unknown funct, or a register-form instruction with a nonzero shamt changes no register and no data word. It advances the PC by 4 and sets illegal, which then stays high until reset.
- R10: An lw or sw whose address has nonzero low two bits, or a jr to such an address, acts as in R9: no effect, PC+4, and illegal set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Write load_data into the instruction store and hold the core |
| load_addr | input | 6 | Instruction word index to write |
| load_data | input | 32 | Instruction word to write |
| dbg_sel | input | 5 | Register number for the debug read |
| dbg_data | output | 32 | Current value of register dbg_sel |
| pc | output | 32 | Program counter (byte address) |
| halted | output | 1 | High once a halt word has executed |
| illegal | output | 1 | Sticky flag set by an unrecognised or misaligned instruction |

## Verification
The hardest behaviour to reach from the ports is control flow that leaves no direct trace. A backward branch taken several times, a call with jal followed by a return through jr, and a misaligned jr that must fall through can only be seen through the register values they leave behind. Each scenario is therefore a short directed program. Its registers accumulate a value that differs for every wrong path: a loop count, a skipped increment, a marker written only on the correct return. After halt, those registers and the final pc are read through the debug port. Misaligned stores are exposed by loading the target word back and comparing it with the value stored earlier.

// File: rtl/scp_pkg.sv
// Shared encodings and control types for the single-cycle core.
// Assumes 32-bit instruction words with a 6-bit primary opcode.
package scp_pkg;
    localparam logic [5:0] OP_RTYPE = 6'b000000;
    localparam logic [5:0] OP_ADDI  = 6'b001000;
    localparam logic [5:0] OP_LW    = 6'b100011;
    localparam logic [5:0] OP_SW    = 6'b101011;
    localparam logic [5:0] OP_BEQ   = 6'b000100;
    localparam logic [5:0] OP_BNE   = 6'b000101;
    localparam logic [5:0] OP_J     = 6'b000010;
    localparam logic [5:0] OP_JAL   = 6'b000011;
    localparam logic [5:0] OP_HALT  = 6'b111111;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_SLT = 6'b101010;
    localparam logic [5:0] FN_JR  = 6'b001000;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_SLT = 2'd2
    } alu_op_e;

    typedef struct packed {
        logic    reg_we;
        logic    dst_rt;
        logic    use_imm;
        logic    mem_rd;
        logic    mem_wr;
        logic    br_eq;
        logic    br_ne;
        logic    jump;
        logic    link;
        logic    jreg;
        logic    halt;
        logic    bad;
        alu_op_e alu_op;
    } ctrl_t;
endpackage

// File: rtl/scp_decode.sv
// Instruction decoder: turns opcode, shamt and funct into control signals.
// Assumes the caller masks side effects when ctrl.bad is set.
module scp_decode
    import scp_pkg::*;
(
    input  logic [5:0] op,
    input  logic [4:0] shamt,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);
    // Map each supported encoding onto its control word; anything else is bad.
    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        case (op)
            OP_RTYPE: begin
                if (shamt != 5'd0) begin
                    ctrl.bad = 1'b1;
                end else begin
                    case (funct)
                        FN_ADD:  ctrl.reg_we = 1'b1;
                        FN_SUB:  begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SUB; end
                        FN_SLT:  begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SLT; end
                        FN_JR:   ctrl.jreg = 1'b1;
                        default: ctrl.bad = 1'b1;
                    endcase
                end
            end
            OP_ADDI: begin ctrl.reg_we = 1'b1; ctrl.dst_rt = 1'b1; ctrl.use_imm = 1'b1; end
            OP_LW: begin
                ctrl.reg_we = 1'b1; ctrl.dst_rt = 1'b1; ctrl.use_imm = 1'b1; ctrl.mem_rd = 1'b1;
            end
            OP_SW:   begin ctrl.use_imm = 1'b1; ctrl.mem_wr = 1'b1; end
            OP_BEQ:  ctrl.br_eq = 1'b1;
            OP_BNE:  ctrl.br_ne = 1'b1;
            OP_J:    ctrl.jump = 1'b1;
            OP_JAL:  begin ctrl.jump = 1'b1; ctrl.link = 1'b1; ctrl.reg_we = 1'b1; end
            OP_HALT: ctrl.halt = 1'b1;
            default: ctrl.bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/scp_alu.sv
// Arithmetic unit: add, subtract and signed set-less-than.
// Purely combinational; the caller picks the operands.
module scp_alu
    import scp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] res
);
    // Select the result for the requested operation.
    always_comb begin
        case (op)
            ALU_SUB: res = a - b;
            ALU_SLT: res = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: res = a + b;
        endcase
    end
endmodule

// File: rtl/scp_regfile.sv
// Register file: two read ports for execution, one debug read port and one
// write port. Entry 0 is never written, so it always reads as zero.
module scp_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    input  logic [AW-1:0] ra3,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    output logic [W-1:0]  rd3
);
    logic [W-1:0] regs [NREG];

    // Clear every entry on reset; otherwise store writes to nonzero entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    // Asynchronous reads for the execution ports and the debug port.
    assign rd1 = regs[ra1];
    assign rd2 = regs[ra2];
    assign rd3 = regs[ra3];

    // R3: a write to a nonzero entry is visible on the next cycle.
    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr != '0) |=> (regs[$past(waddr)] == $past(wdata)));

    // R5: entry 0 stays zero even right after a write aimed at it.
    p_zero_reg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == '0) |=> (rd3 == '0 || ra3 != '0));
endmodule

// File: rtl/scp_core.sv
// Single-cycle processor top: PC, instruction and data stores, and the
// datapath joining decoder, register file and ALU. Assumes the program is
// written through the load port while the core is held (reset or load_en).
module scp_core
    import scp_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_en,
    input  logic [IAW-1:0] load_addr,
    input  logic [31:0]    load_data,
    input  logic [4:0]     dbg_sel,
    output logic [31:0]    dbg_data,
    output logic [31:0]    pc,
    output logic           halted,
    output logic           illegal
);
    logic [31:0] imem [IMEM_WORDS];
    logic [31:0] dmem [DMEM_WORDS];

    logic        run;
    logic [31:0] instr, imm_sx, rd1, rd2, alu_b, alu_res, dm_rdata;
    logic [31:0] pc_next4, br_tgt, j_tgt, pc_nxt, wb_data;
    logic [4:0]  wb_addr;
    logic        fault, take_br, rf_we, dm_we;
    ctrl_t       ctrl;

    assign run      = !load_en && !halted;
    assign instr    = imem[pc[IAW+1:2]];
    assign imm_sx   = {{16{instr[15]}}, instr[15:0]};
    assign pc_next4 = pc + 32'd4;
    assign br_tgt   = pc_next4 + {imm_sx[29:0], 2'b00};
    assign j_tgt    = {pc_next4[31:28], instr[25:0], 2'b00};

    scp_decode u_dec (
        .op    (instr[31:26]),
        .shamt (instr[10:6]),
        .funct (instr[5:0]),
        .ctrl  (ctrl)
    );

    scp_regfile #(.NREG(32), .W(32)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (wb_addr),
        .wdata (wb_data),
        .ra1   (instr[25:21]),
        .ra2   (instr[20:16]),
        .ra3   (dbg_sel),
        .rd1   (rd1),
        .rd2   (rd2),
        .rd3   (dbg_data)
    );

    assign alu_b = ctrl.use_imm ? imm_sx : rd2;

    scp_alu #(.W(32)) u_alu (
        .a   (rd1),
        .b   (alu_b),
        .op  (ctrl.alu_op),
        .res (alu_res)
    );

    // Flag unknown encodings and misaligned word accesses or register jumps.
    always_comb begin
        fault = ctrl.bad;
        if ((ctrl.mem_rd || ctrl.mem_wr) && alu_res[1:0] != 2'b00) fault = 1'b1;
        if (ctrl.jreg && rd1[1:0] != 2'b00) fault = 1'b1;
    end

    assign take_br = (ctrl.br_eq && rd1 == rd2) || (ctrl.br_ne && rd1 != rd2);

    // Choose the next PC; a faulting instruction simply falls through.
    always_comb begin
        if (fault)             pc_nxt = pc_next4;
        else if (ctrl.jreg)    pc_nxt = rd1;
        else if (ctrl.jump)    pc_nxt = j_tgt;
        else if (take_br)      pc_nxt = br_tgt;
        else                   pc_nxt = pc_next4;
    end

    assign dm_rdata = dmem[alu_res[DAW+1:2]];
    assign rf_we    = run && ctrl.reg_we && !fault;
    assign dm_we    = run && ctrl.mem_wr && !fault;
    assign wb_addr  = ctrl.link ? 5'd31 : (ctrl.dst_rt ? instr[20:16] : instr[15:11]);
    assign wb_data  = ctrl.link ? pc_next4 : (ctrl.mem_rd ? dm_rdata : alu_res);

    // Advance the PC, latch halt, and record faults while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc      <= '0;
            halted  <= 1'b0;
            illegal <= 1'b0;
        end else if (run) begin
            if (ctrl.halt) halted <= 1'b1;
            else           pc     <= pc_nxt;
            if (fault)     illegal <= 1'b1;
        end
    end

    // Write program words from the load port.
    always_ff @(posedge clk) begin
        if (load_en) imem[load_addr] <= load_data;
    end

    // Store data words for executed sw instructions.
    always_ff @(posedge clk) begin
        if (dm_we) dmem[alu_res[DAW+1:2]] <= rd2;
    end

    // R8: once halted, the core stays halted with a frozen PC.
    p_halt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc)));

    // R6: a non-transfer instruction moves the PC forward by one word.
    p_pc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ctrl.halt && (fault || !(ctrl.jump || ctrl.jreg || take_br)))
        |=> (pc == $past(pc) + 32'd4));

    // R10: the PC never becomes misaligned.
    p_pc_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pc[1:0] == 2'b00);

    // R9: the illegal flag holds until reset.
    p_illegal_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> illegal);
endmodule

// File: tb/scp_core_tb.sv
`timescale 1ns/1ps
module scp_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [5:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic [4:0]  dbg_sel = '0;
    logic [31:0] dbg_data, pc;
    logic        halted, illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] prog [64];

    localparam logic [31:0] HALT_W = 32'hFC00_0000;

    always #2.5 clk = ~clk;

    scp_core u_dut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .dbg_sel(dbg_sel), .dbg_data(dbg_data),
        .pc(pc), .halted(halted), .illegal(illegal)
    );

    function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [5:0] fn);
        return {6'b000000, rs, rt, rd, 5'b00000, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input int imm);
        logic [31:0] v;
        v = imm;
        return {op, rs, rt, v[15:0]};
    endfunction

    function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] t);
        return {op, t};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic read_reg(input logic [4:0] r, output logic [31:0] v);
        dbg_sel = r;
        #0.5;
        v = dbg_data;
    endtask

    task automatic check_reg(input string tag, input logic [4:0] r, input logic [31:0] exp);
        logic [31:0] v;
        read_reg(r, v);
        check(tag, v, exp);
    endtask

    // Hold reset, write n program words, then release; checks the reset state (R1).
    task automatic boot(input int n);
        @(negedge clk);
        rst_n   = 1'b0;
        load_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            load_addr = i[5:0];
            load_data = prog[i];
            @(negedge clk);
        end
        load_en = 1'b0;
        @(negedge clk);
        check("R1 pc after reset", pc, 32'd0);
        check("R1 halted after reset", {31'd0, halted}, 32'd0);
        check("R1 illegal after reset", {31'd0, illegal}, 32'd0);
        check_reg("R1 reg8 cleared", 5'd8, 32'd0);
        check_reg("R1 reg9 cleared", 5'd9, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic wait_halt(input string tag);
        int n;
        n = 0;
        while (!halted && n < 400) begin
            @(negedge clk);
            n++;
        end
        check({tag, " reached halt"}, {31'd0, halted}, 32'd1);
    endtask

    task automatic t_arith;
        prog[0]  = enc_i(6'b001000, 5'd0, 5'd8, 7);
        prog[1]  = enc_i(6'b001000, 5'd0, 5'd9, -3);
        prog[2]  = enc_r(5'd8, 5'd9, 5'd10, 6'b100000);
        prog[3]  = enc_r(5'd9, 5'd8, 5'd11, 6'b100010);
        prog[4]  = enc_r(5'd9, 5'd8, 5'd12, 6'b101010);
        prog[5]  = enc_r(5'd8, 5'd9, 5'd13, 6'b101010);
        prog[6]  = enc_i(6'b001000, 5'd0, 5'd0, 5);
        prog[7]  = enc_r(5'd0, 5'd8, 5'd14, 6'b100000);
        prog[8]  = enc_i(6'b001000, 5'd0, 5'd15, -32768);
        prog[9]  = enc_i(6'b001000, 5'd0, 5'd16, 32767);
        prog[10] = HALT_W;
        boot(11);
        wait_halt("R8 arith");
        check_reg("R2 add 7+-3", 5'd10, 32'd4);
        check_reg("R2 sub -3-7", 5'd11, 32'hFFFF_FFF6);
        check_reg("R2 slt signed true", 5'd12, 32'd1);
        check_reg("R2 slt signed false", 5'd13, 32'd0);
        check_reg("R3 addi negative", 5'd9, 32'hFFFF_FFFD);
        check_reg("R3 addi min imm", 5'd15, 32'hFFFF_8000);
        check_reg("R3 addi max imm", 5'd16, 32'h0000_7FFF);
        check_reg("R5 reg0 after write", 5'd0, 32'd0);
        check_reg("R5 reg0 read as zero", 5'd14, 32'd7);
        check("R8 halt pc", pc, 32'd40);
        repeat (5) @(negedge clk);
        check("R8 pc frozen", pc, 32'd40);
        check("R9 no illegal on valid code", {31'd0, illegal}, 32'd0);
    endtask

    task automatic t_memory;
        prog[0] = enc_i(6'b001000, 5'd0, 5'd8, 16);
        prog[1] = enc_i(6'b001000, 5'd0, 5'd9, 123);
        prog[2] = enc_i(6'b101011, 5'd8, 5'd9, 4);
        prog[3] = enc_i(6'b001000, 5'd0, 5'd11, 24);
        prog[4] = enc_i(6'b100011, 5'd11, 5'd12, -4);
        prog[5] = enc_i(6'b001000, 5'd0, 5'd9, -8);
        prog[6] = enc_i(6'b101011, 5'd8, 5'd9, 0);
        prog[7] = enc_i(6'b100011, 5'd8, 5'd10, 0);
        prog[8] = enc_i(6'b100011, 5'd8, 5'd13, 4);
        prog[9] = HALT_W;
        boot(10);
        wait_halt("R4 memory");
        check_reg("R4 load negative offset", 5'd12, 32'd123);
        check_reg("R4 load stored word", 5'd10, 32'hFFFF_FFF8);
        check_reg("R4 earlier word kept", 5'd13, 32'd123);
        check("R8 memory halt pc", pc, 32'd36);
    endtask

    task automatic t_branch;
        prog[0] = enc_i(6'b001000, 5'd0, 5'd8, 3);
        prog[1] = enc_i(6'b001000, 5'd0, 5'd9, 0);
        prog[2] = enc_i(6'b001000, 5'd9, 5'd9, 5);
        prog[3] = enc_i(6'b001000, 5'd8, 5'd8, -1);
        prog[4] = enc_i(6'b000101, 5'd8, 5'd0, -3);
        prog[5] = enc_i(6'b000100, 5'd8, 5'd0, 1);
        prog[6] = enc_i(6'b001000, 5'd9, 5'd9, 100);
        prog[7] = enc_i(6'b000100, 5'd9, 5'd8, 1);
        prog[8] = enc_i(6'b001000, 5'd0, 5'd10, 1);
        prog[9] = HALT_W;
        boot(10);
        wait_halt("R6 branch");
        check_reg("R6 backward bne loop count", 5'd9, 32'd15);
        check_reg("R6 loop counter", 5'd8, 32'd0);
        check_reg("R6 beq not taken falls through", 5'd10, 32'd1);
        check("R6 branch halt pc", pc, 32'd36);
    endtask

    task automatic t_jump;
        prog[0] = enc_j(6'b000011, 26'd5);
        prog[1] = enc_i(6'b001000, 5'd0, 5'd9, 2);
        prog[2] = enc_j(6'b000010, 26'd7);
        prog[3] = enc_i(6'b001000, 5'd0, 5'd9, 77);
        prog[4] = HALT_W;
        prog[5] = enc_i(6'b001000, 5'd0, 5'd8, 9);
        prog[6] = enc_r(5'd31, 5'd0, 5'd0, 6'b001000);
        prog[7] = HALT_W;
        boot(8);
        wait_halt("R7 jump");
        check_reg("R7 jal link value", 5'd31, 32'd4);
        check_reg("R7 subroutine ran", 5'd8, 32'd9);
        check_reg("R7 jr returned, j skipped", 5'd9, 32'd2);
        check("R7 j target pc", pc, 32'd28);
    endtask

    task automatic t_illegal;
        prog[0]  = enc_i(6'b001000, 5'd0, 5'd8, 16);
        prog[1]  = 32'h4000_0000;
        prog[2]  = enc_r(5'd8, 5'd8, 5'd9, 6'b000000);
        prog[3]  = enc_i(6'b001000, 5'd0, 5'd10, 5);
        prog[4]  = enc_i(6'b101011, 5'd8, 5'd10, 0);
        prog[5]  = enc_i(6'b001000, 5'd0, 5'd12, 99);
        prog[6]  = enc_i(6'b101011, 5'd8, 5'd12, 2);
        prog[7]  = enc_i(6'b100011, 5'd8, 5'd11, 0);
        prog[8]  = enc_i(6'b100011, 5'd8, 5'd13, 3);
        prog[9]  = enc_i(6'b001000, 5'd0, 5'd14, 26);
        prog[10] = enc_r(5'd14, 5'd0, 5'd0, 6'b001000);
        prog[11] = enc_i(6'b001000, 5'd0, 5'd15, 1);
        prog[12] = {6'b000000, 5'd8, 5'd8, 5'd16, 5'd3, 6'b100000};
        prog[13] = HALT_W;
        boot(14);
        wait_halt("R9 illegal");
        check_reg("R9 unknown funct no write", 5'd9, 32'd0);
        check_reg("R9 nonzero shamt no write", 5'd16, 32'd0);
        check("R9 illegal flag sticky", {31'd0, illegal}, 32'd1);
        check_reg("R10 misaligned sw no write", 5'd11, 32'd5);
        check_reg("R10 misaligned lw no write", 5'd13, 32'd0);
        check_reg("R10 misaligned jr falls through", 5'd15, 32'd1);
        check("R10 final pc", pc, 32'd52);
    endtask

    initial begin
        t_arith();
        t_memory();
        t_branch();
        t_jump();
        t_illegal();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired got=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule